// File: doc/BRIEF.md
# Streaming CRC-32 Accumulator

This block sits beside the data path of a memory-to-memory copy engine and folds every 32-bit word that passes through into a running CRC-32. Every cycle in which the word strobe is high and the engine's enable is set, one complete word is absorbed. When a word also carries the end-of-frame marker, the block raises a single-cycle completion pulse once that word has been folded in. The completion pulse is meant for an interrupt controller outside the block.

Three run-time options shape the calculation. A clear input puts the accumulator back to its seed. A byte-order option reverses the byte order of each incoming word before it enters the shift network. An output option reports the stored remainder with its bits reversed. Register access and interrupt masking stay outside the block. The block only drives the result value and the completion pulse.

Top module: `crc32_stream`

## Requirements
- R1: While `crc_en` is low, a word presented with `din_valid` high leaves `crc_result` unchanged.
- R2: A cycle with `crc_clr` high sets the accumulator to the seed 0xFFFFFFFF, and `crc_result` shows it from the next cycle.
- R3: With `swap_in` high, the word is byte-reversed before absorption: `din[7:0]` becomes the most significant byte and `din[31:24]` becomes the least significant byte.
- R4: With `rev_out` high, `crc_result` bit i equals accumulator bit 31-i. The option acts combinationally on the stored value and does not alter the accumulator.
- R5: An absorbed word updates the accumulator with the polynomial 0x04C11DB7, non-reflected, data bit 31 first, with no final XOR. The new value appears on `crc_result` in the cycle after the word is presented.
- R6: `crc_done` is high for exactly the one cycle after a word with `din_last` high is absorbed. It is low at all other times.
- R7: A cycle with `din_valid` low and `crc_clr` low leaves the accumulator unchanged.
- R8: When `crc_clr` and an enabled, valid word arrive together, the clear wins. The word is dropped and no `crc_done` pulse follows, even if `din_last` is high.
- R9: After `rst_n` is asserted, `crc_result` reads 0xFFFFFFFF (with `rev_out` low) and `crc_done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crc_en | input | 1 | Allows words to be absorbed |
| crc_clr | input | 1 | Synchronous return of the accumulator to its seed |
| swap_in | input | 1 | Byte-reverse each incoming word |
| rev_out | input | 1 | Bit-reverse the reported result |
| din_valid | input | 1 | Word strobe |
| din | input | 32 | Data word |
| din_last | input | 1 | Marks the final word of a frame |
| crc_result | output | 32 | Current remainder, optionally reversed |
| crc_done | output | 1 | One-cycle pulse after the final word is absorbed |

## Verification
Both the accumulator and the completion pulse are registered once. The effect of a word, a clear or an ignored strobe is therefore due exactly one clock edge after the inputs are driven. The output reversal, by contrast, is due in the same cycle. The bench drives inputs on the falling edge and samples on the next falling edge, which falls between the edge that registered the word and the one after it. In that same window it confirms that the pulse from a final word is gone one cycle later.

// File: rtl/crc32_pkg.sv
package crc32_pkg;
    localparam int CW = 32;
    localparam logic [CW-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [CW-1:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef struct packed {
        logic [CW-1:0] acc;
        logic          done;
    } crc_state_t;
endpackage

// File: rtl/crc32_word_order.sv
module crc32_word_order #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] word_in,
    input  logic          swap,
    output logic [DW-1:0] word_out
);
    localparam int NB = DW / 8;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign word_out[b*8 +: 8] = swap ? word_in[(NB-1-b)*8 +: 8] : word_in[b*8 +: 8];
    end
endmodule

// File: rtl/crc32_word_step.sv
module crc32_word_step
    import crc32_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [CW-1:0] crc_in,
    input  logic [DW-1:0] data,
    output logic [CW-1:0] crc_out
);
    logic [CW-1:0] stage [0:DW];

    assign stage[0] = crc_in;

    // One shift stage per data bit, most significant bit first.
    for (genvar g = 0; g < DW; g++) begin : g_bit
        logic fb;
        assign fb = stage[g][CW-1] ^ data[DW-1-g];
        assign stage[g+1] = {stage[g][CW-2:0], 1'b0} ^ ({CW{fb}} & CRC_POLY);
    end

    assign crc_out = stage[DW];
endmodule

// File: rtl/crc32_stream.sv
module crc32_stream
    import crc32_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          crc_en,
    input  logic          crc_clr,
    input  logic          swap_in,
    input  logic          rev_out,
    input  logic          din_valid,
    input  logic [DW-1:0] din,
    input  logic          din_last,
    output logic [CW-1:0] crc_result,
    output logic          crc_done
);
    crc_state_t    state_d, state_q;
    logic [DW-1:0] ordered_word;
    logic [CW-1:0] stepped_acc;
    logic [CW-1:0] reversed_acc;
    logic          absorb;

    crc32_word_order #(.DW(DW)) u_order (
        .word_in  (din),
        .swap     (swap_in),
        .word_out (ordered_word)
    );

    crc32_word_step #(.DW(DW)) u_step (
        .crc_in  (state_q.acc),
        .data    (ordered_word),
        .crc_out (stepped_acc)
    );

    assign absorb = crc_en && din_valid && !crc_clr;

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (crc_clr) begin
            state_d.acc = CRC_SEED;
        end else if (absorb) begin
            state_d.acc  = stepped_acc;
            state_d.done = din_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.acc  <= CRC_SEED;
            state_q.done <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar i = 0; i < CW; i++) begin : g_rev
        assign reversed_acc[i] = state_q.acc[CW-1-i];
    end

    assign crc_result = rev_out ? reversed_acc : state_q.acc;
    assign crc_done   = state_q.done;

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(crc_en) && !$past(crc_clr)) |-> $stable(state_q.acc)); // R1
    AST_CLEAR_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(crc_clr) |-> (state_q.acc == CRC_SEED)); // R2
    AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        crc_done |-> ($past(din_last) && $past(din_valid) && $past(crc_en))); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(din_valid) && !$past(crc_clr)) |-> $stable(state_q.acc)); // R7
    AST_CLEAR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(crc_clr) |-> !crc_done); // R8
endmodule

// File: tb/crc32_stream_test.sv
module crc32_stream_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crc_en = 1'b0;
    logic        crc_clr = 1'b0;
    logic        swap_in = 1'b0;
    logic        rev_out = 1'b0;
    logic        din_valid = 1'b0;
    logic [31:0] din = '0;
    logic        din_last = 1'b0;
    logic [31:0] crc_result;
    logic        crc_done;

    int checks = 0;
    int fails = 0;

    always #(PERIOD/2) clk = ~clk;

    crc32_stream uut (
        .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .crc_clr(crc_clr),
        .swap_in(swap_in), .rev_out(rev_out), .din_valid(din_valid),
        .din(din), .din_last(din_last), .crc_result(crc_result), .crc_done(crc_done)
    );

    // stimulus: {swap, last, data}
    localparam logic [33:0] VEC [0:11] = '{
        {1'b0, 1'b0, 32'h0000_0000},
        {1'b0, 1'b1, 32'h1234_5678},
        {1'b0, 1'b0, 32'hFFFF_FFFF},
        {1'b1, 1'b0, 32'hDEAD_BEEF},
        {1'b1, 1'b1, 32'h0102_0304},
        {1'b0, 1'b0, 32'h8000_0001},
        {1'b0, 1'b0, 32'hA5A5_5A5A},
        {1'b1, 1'b0, 32'h00FF_00FF},
        {1'b0, 1'b1, 32'hCAFE_F00D},
        {1'b0, 1'b1, 32'h0000_0001},
        {1'b1, 1'b0, 32'h8000_0000},
        {1'b0, 1'b1, 32'h3141_5926}
    };

    function automatic logic [31:0] model_step(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r = c;
        for (int i = 31; i >= 0; i--) begin
            logic top = r[31] ^ d[i];
            r = {r[30:0], 1'b0};
            if (top) r = r ^ 32'h04C1_1DB7;
        end
        return r;
    endfunction

    function automatic logic [31:0] bswap(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    function automatic logic [31:0] brev(input logic [31:0] d);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = d[31-i];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] exp;
        logic [31:0] held;

        tick(); tick();
        // R9 reset state
        check("R9 reset result", crc_result, 32'hFFFF_FFFF);
        check("R9 reset done", {31'b0, crc_done}, 32'h0);
        rst_n = 1'b1;
        tick();

        // R5 / R3 / R6 table walk
        exp = 32'hFFFF_FFFF;
        crc_en = 1'b1;
        for (int k = 0; k < 12; k++) begin
            swap_in   = VEC[k][33];
            din_last  = VEC[k][32];
            din       = VEC[k][31:0];
            din_valid = 1'b1;
            tick();
            exp = model_step(exp, VEC[k][33] ? bswap(VEC[k][31:0]) : VEC[k][31:0]);
            check(VEC[k][33] ? "R3 swapped word" : "R5 word update", crc_result, exp);
            check("R6 done after last", {31'b0, crc_done}, {31'b0, VEC[k][32]});
        end
        din_valid = 1'b0; din_last = 1'b0; swap_in = 1'b0;
        tick();
        check("R6 pulse ends", {31'b0, crc_done}, 32'h0);
        check("R7 idle hold", crc_result, exp);

        // R4 output reversal, same cycle, no effect on accumulator
        rev_out = 1'b1;
        #1;
        check("R4 reversed view", crc_result, brev(exp));
        rev_out = 1'b0;
        #1;
        check("R4 accumulator untouched", crc_result, exp);

        // R1 disabled word ignored
        held = crc_result;
        crc_en = 1'b0; din_valid = 1'b1; din = 32'h5555_AAAA; din_last = 1'b1;
        tick();
        check("R1 disabled hold", crc_result, held);
        check("R1 no done when disabled", {31'b0, crc_done}, 32'h0);
        din_valid = 1'b0; din_last = 1'b0; crc_en = 1'b1;

        // R2 clear
        crc_clr = 1'b1;
        tick();
        crc_clr = 1'b0;
        check("R2 clear to seed", crc_result, 32'hFFFF_FFFF);

        // R8 clear beats word, no done
        din_valid = 1'b1; din = 32'h1357_9BDF; din_last = 1'b0;
        tick();
        exp = model_step(32'hFFFF_FFFF, 32'h1357_9BDF);
        check("R5 after clear", crc_result, exp);
        crc_clr = 1'b1; din = 32'h2468_ACE0; din_last = 1'b1;
        tick();
        check("R8 clear priority", crc_result, 32'hFFFF_FFFF);
        check("R8 no done", {31'b0, crc_done}, 32'h0);
        crc_clr = 1'b0; din_valid = 1'b0; din_last = 1'b0;
        tick();

        // R5 known single word from seed: zero word
        din_valid = 1'b1; din = 32'h0; din_last = 1'b1;
        tick();
        check("R5 zero word", crc_result, model_step(32'hFFFF_FFFF, 32'h0));
        check("R6 single word frame", {31'b0, crc_done}, 32'h1);
        din_valid = 1'b0; din_last = 1'b0;
        tick();
        check("R6 single cycle", {31'b0, crc_done}, 32'h0);

        summary();
    end
endmodule